// File: doc/BRIEF.md
# Single-Transfer DMA Channel Arbiter

This block decides which of four DMA channels may use the shared bus, one transfer at a time. After every transfer it gives the bus back to the CPU for at least one cycle. Lower channel numbers have higher priority. When several channels are pending, the arbiter avoids the channel it served last. As a result, the two highest-priority pending channels take turns, and lower-priority channels wait until one of those two drops out.

A channel drops out when its terminal-count flag is high while its transfer completes. Its request then stays masked until a re-arm pulse for that channel clears the mask. No data flows through the block, so there is no valid/ready interface. Every pin is a plain level or a one-cycle strobe, and the grant has no back-pressure beyond the transfer-done strobe. A granted channel keeps the bus until the strobe arrives.

Top module: `dma_single_arb`

## Requirements
- R1: After reset, `cpu_owns` is 1, `grant` is all zero, and no channel counts as last served.
- R2: While no unmasked channel requests, the bus stays with the CPU (`cpu_owns`=1, `grant`=0) for any number of cycles.
- R3: During a DMA slot, exactly one bit of `grant` is high. Bit i means channel i. `cpu_owns` is 0. During a CPU slot, `grant` is zero and `cpu_owns` is 1.
- R4: A grant stays unchanged until `xfer_done` is sampled high. A `xfer_done` pulse during a CPU slot has no effect.
- R5: The clock edge that samples `xfer_done` during a DMA slot clears the grant. Every transfer is followed by at least one CPU cycle. Arbitration happens on the edge that ends that CPU cycle.
- R6: With a single pending channel, that channel is granted again after every CPU slot.
- R7: With two pending channels, the first grant after reset goes to the lower number, and after that the two alternate one transfer each.
- R8: With three or more pending channels, the grant goes to the highest-priority pending channel other than the last-served one. So the two highest-priority channels alternate and the others wait.
- R9: If `tc[i]` is high when `xfer_done` completes a transfer of channel i, channel i is masked. The next-highest pending channel then alternates with the remaining one.
- R10: A one-cycle `rearm[i]` pulse clears the mask of channel i, and that channel takes part in later decisions again.
- R11: A request raised in the CPU cycle right after a transfer ends takes part in the decision made at the end of that cycle.
- R12: A `tc` bit of a channel that is not granted, or a `tc` bit outside a `xfer_done` strobe, masks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Per-channel transfer request levels, bit 0 highest priority |
| xfer_done | input | 1 | One-cycle strobe that ends the current transfer |
| tc | input | 4 | Per-channel terminal-count flags, sampled with `xfer_done` |
| rearm | input | 4 | Per-channel pulse that clears a terminal-count mask |
| grant | output | 4 | One-hot grant of the bus to a channel |
| cpu_owns | output | 1 | High while the CPU owns the bus |

## Verification
The bench builds the block with its default of four channels. With four channels it can reach every ordering in scope:
- a lone requester;
- a pair taking turns;
- three requesters where the lowest-priority one starves until a higher one terminates;
- a late request joining the next decision;
- re-arming a masked channel while others alternate.

The parameter values are small, so every grant sequence fits in a few dozen cycles. Each one is checked against a hand-derived order.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    SLOT_CPU = 1'b0,
    SLOT_DMA = 1'b1
  } slot_e;
endpackage

// File: rtl/dma_arb_pick.sv
// Combinational choice: lowest-numbered eligible channel that was not served
// last; falls back to the last-served channel when it is the only one left.
module dma_arb_pick #(
  parameter int N_CH = 4
) (
  input  logic [N_CH-1:0] elig,
  input  logic [N_CH-1:0] last,
  output logic [N_CH-1:0] pick,
  output logic            any
);
  localparam logic [N_CH-1:0] ONE = 1;

  logic [N_CH-1:0] others;
  logic [N_CH-1:0] base;

  always_comb begin
    others = elig & ~last;
    base   = (|others) ? others : elig;
    pick   = base & (~base + ONE);
    any    = |elig;
  end

  always_comb begin
    assert_pick_in_elig_R3: assert ((pick & ~elig) == '0)
      else $error("pick outside eligible set");
    assert_pick_onehot_R3: assert ($onehot0(pick) && ((pick != '0) == any))
      else $error("pick not one-hot");
    if ((elig & ~last) != '0)
      assert_avoid_last_R8: assert ((pick & last) == '0)
        else $error("last-served channel picked while another waits");
  end
endmodule

// File: rtl/dma_arb_mask.sv
// Terminal-count mask: set on completion with tc, cleared by re-arm.
module dma_arb_mask #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] set_hit,
  input  logic [N_CH-1:0] rearm,
  output logic [N_CH-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask & ~rearm) | set_hit;
  end

  assert_tc_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit != '0) |=> ((mask & $past(set_hit)) == $past(set_hit)))
    else $error("terminal count did not mask channel");

  assert_rearm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rearm & ~set_hit) != '0) |=> ((mask & $past(rearm & ~set_hit)) == '0))
    else $error("re-arm did not clear mask");
endmodule

// File: rtl/dma_arb_slot.sv
// Slot sequencer: CPU slot (arbitrate) -> DMA slot (hold) -> CPU slot.
module dma_arb_slot
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] pick,
  input  logic            any,
  input  logic            xfer_done,
  output logic [N_CH-1:0] grant,
  output logic [N_CH-1:0] last,
  output logic            cpu_owns
);
  slot_e slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot  <= SLOT_CPU;
      grant <= '0;
      last  <= '0;
    end else begin
      unique case (slot)
        SLOT_CPU: if (any) begin
          grant <= pick;
          slot  <= SLOT_DMA;
        end
        SLOT_DMA: if (xfer_done) begin
          last  <= grant;
          grant <= '0;
          slot  <= SLOT_CPU;
        end
        default: slot <= SLOT_CPU;
      endcase
    end
  end

  assign cpu_owns = (slot == SLOT_CPU);

  assert_grant_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_owns ? (grant == '0) : ($countones(grant) == 1))
    else $error("grant shape wrong for slot");

  assert_grant_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && !xfer_done) |=> (grant == $past(grant)))
    else $error("grant changed before transfer done");

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && xfer_done) |=> (cpu_owns && grant == '0))
    else $error("bus not returned to CPU after transfer");

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_owns && !any) |=> cpu_owns)
    else $error("DMA slot started without a request");
endmodule

// File: rtl/dma_single_arb.sv
module dma_single_arb #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req,
  input  logic            xfer_done,
  input  logic [N_CH-1:0] tc,
  input  logic [N_CH-1:0] rearm,
  output logic [N_CH-1:0] grant,
  output logic            cpu_owns
);
  logic [N_CH-1:0] mask;
  logic [N_CH-1:0] elig;
  logic [N_CH-1:0] last;
  logic [N_CH-1:0] pick;
  logic [N_CH-1:0] tc_hit;
  logic            any;

  assign elig   = req & ~mask;
  assign tc_hit = {N_CH{xfer_done}} & grant & tc;

  dma_arb_mask #(.N_CH(N_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_hit(tc_hit), .rearm(rearm), .mask(mask)
  );

  dma_arb_pick #(.N_CH(N_CH)) u_pick (
    .elig(elig), .last(last), .pick(pick), .any(any)
  );

  dma_arb_slot #(.N_CH(N_CH)) u_slot (
    .clk(clk), .rst_n(rst_n), .pick(pick), .any(any), .xfer_done(xfer_done),
    .grant(grant), .last(last), .cpu_owns(cpu_owns)
  );

  assert_tc_stray_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_owns && (tc != '0)) |=> ($past(mask) == (mask | $past(rearm))) || (mask == ($past(mask) & ~$past(rearm))))
    else $error("stray terminal count changed mask");
endmodule

// File: tb/dma_single_arb_test.sv
`timescale 1ns/1ps
module dma_single_arb_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         xfer_done = 1'b0;
  logic [N-1:0] tc = '0;
  logic [N-1:0] rearm = '0;
  logic [N-1:0] grant;
  logic         cpu_owns;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_single_arb #(.N_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
    .tc(tc), .rearm(rearm), .grant(grant), .cpu_owns(cpu_owns)
  );

  task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; xfer_done = 1'b0; tc = '0; rearm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called at a negedge inside a CPU slot; decision is taken at the next edge.
  task automatic serve(input string tag, input int ch,
                       input logic [N-1:0] tc_v, input logic [N-1:0] rearm_v);
    logic [N-1:0] exp_g;
    exp_g = '0;
    exp_g[ch] = 1'b1;
    check({tag, " cpu slot before grant R5"}, {cpu_owns, grant}, {1'b1, {N{1'b0}}});
    @(negedge clk);
    check({tag, " grant R3"}, {cpu_owns, grant}, {1'b0, exp_g});
    rearm = rearm_v;
    @(negedge clk);
    rearm = '0;
    check({tag, " hold R4"}, {cpu_owns, grant}, {1'b0, exp_g});
    xfer_done = 1'b1; tc = tc_v;
    @(negedge clk);
    xfer_done = 1'b0; tc = '0;
    check({tag, " release R5"}, {cpu_owns, grant}, {1'b1, {N{1'b0}}});
  endtask

  task automatic t_reset_idle();
    do_reset();
    check("reset R1", {cpu_owns, grant}, {1'b1, {N{1'b0}}});
    repeat (8) @(negedge clk);
    check("idle R2", {cpu_owns, grant}, {1'b1, {N{1'b0}}});
    xfer_done = 1'b1; tc = 4'b1111;
    @(negedge clk);
    xfer_done = 1'b0; tc = '0;
    check("done in CPU slot R4", {cpu_owns, grant}, {1'b1, {N{1'b0}}});
    req = 4'b1111;
    serve("no mask after stray R12", 0, '0, '0);
    req = '0;
  endtask

  task automatic t_single();
    do_reset();
    req = 4'b0100;
    serve("single R6 a", 2, '0, '0);
    serve("single R6 b", 2, '0, '0);
    serve("single R6 c", 2, '0, '0);
    req = '0;
  endtask

  task automatic t_pair();
    do_reset();
    req = 4'b1001;
    serve("pair R7 a", 0, '0, '0);
    serve("pair R7 b", 3, '0, '0);
    serve("pair R7 c", 0, '0, '0);
    serve("pair R7 d", 3, '0, '0);
    req = '0;
  endtask

  task automatic t_three_tc_rearm();
    do_reset();
    req = 4'b1101;
    serve("three R8 a", 0, '0, '0);
    serve("three R8 b", 2, '0, '0);
    serve("three R8 c", 0, 4'b0001, '0);
    serve("after tc R9 a", 2, '0, '0);
    serve("after tc R9 b stray tc R12", 3, 4'b0100, '0);
    serve("after tc R9 c", 2, '0, 4'b0001);
    serve("rearm R10", 0, '0, '0);
    serve("rearm R8", 2, '0, '0);
    req = '0;
  endtask

  task automatic t_late();
    do_reset();
    req = 4'b0001;
    serve("late R6", 0, '0, '0);
    req = 4'b1001;
    serve("late request R11", 3, '0, '0);
    serve("late R7", 0, '0, '0);
    req = '0;
  endtask

  initial begin
    t_reset_idle();
    t_single();
    t_pair();
    t_three_tc_rearm();
    t_late();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule